// File: doc/BRIEF.md
# Receive Payload Byte Mapper

This block sits between a receive deframer and a receive FIFO. For every received payload block the deframer delivers a run of bytes, marking the first one with a block-start flag. The mapper tracks each byte's position within the block. A 36-bit selection mask, loaded by software, decides whether the byte at each position is written into the FIFO or discarded.

Software loads the mask through a narrow write port as six registers. Each register carries six mask bits in its low data bits. New mask values are staged and only take over when the next block begins, so no block is filtered by a mix of old and new bits.

In T1 operation the deframer passes the framing bit as one extra byte, placed right after the last payload byte that is in use, and flags it. The mask bit at that position also decides whether the framing bit is forwarded, so one mask both filters payload and selects the framing bit. For example, with two T1 streams the framing bit is controlled by mask bit 12. Forwarded framing bits are marked on the FIFO side.

Top module: `rx_byte_mapper`

## Requirements
- R1: Mask bit x governs the byte at position x of a block (byte x+1). When the bit is 1 the byte is written to the FIFO, and when it is 0 the byte is dropped.
- R2: A write to register address k (0 to 5) loads `cfg_wdata[5:0]` into mask bits 6k+5 down to 6k, so address 5 holds bits 35..30. Data bits 7:6 are ignored, and writes to addresses 6 and 7 change nothing.
- R3: A mask write takes effect at the first block start presented after the write cycle. Bytes of a block already in progress keep using the mask that was loaded at that block's start.
- R4: The byte flagged `in_start` has position 0, and each later valid byte takes the next position. Bytes at position 36 or above are never written.
- R5: An accepted byte produces `fifo_we` high for exactly one cycle, in the cycle after the byte is presented, with `fifo_data` equal to the byte.
- R6: If `fifo_full` is high when a byte that the mask selects is presented, no write occurs. `overflow` goes high in the next cycle and stays high until reset.
- R7: With `t1_mode` = 1, a byte flagged `in_fbit` follows the mask like any other byte. When written, it appears as `fifo_data` = {7'b0, in_data[0]} with `fifo_fbit` = 1. With `t1_mode` = 0 the flag has no effect: the data is unchanged and `fifo_fbit` stays 0.
- R8: After reset the mask is all zeros, and `fifo_we`, `fifo_fbit` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| t1_mode | input | 1 | Enables framing-bit handling |
| cfg_we | input | 1 | Mask register write strobe |
| cfg_addr | input | 3 | Mask register address |
| cfg_wdata | input | 8 | Mask register write data (bits 5:0 used) |
| in_valid | input | 1 | Payload byte present |
| in_start | input | 1 | Byte is the first of a payload block |
| in_fbit | input | 1 | Byte carries the T1 framing bit |
| in_data | input | 8 | Payload byte |
| fifo_full | input | 1 | FIFO cannot accept a write |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| fifo_fbit | output | 1 | Written entry is a framing bit |
| overflow | output | 1 | Sticky: a selected byte met a full FIFO |

## Verification
The FIFO write strobe, data and framing marker are registered once, so each is due in the cycle after the byte is presented. The overflow flag is also due one cycle after the full-FIFO byte. A mask write becomes visible on the first block-start byte presented after the write edge. The bench drives every input at a falling edge, lets one rising edge pass, and samples at the following falling edge, so every check for a byte reads exactly the cycle in which that byte's result is due. Mask changes are always issued as complete write cycles before the block-start byte that should use them, or in the middle of a block to show that they are deferred.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              fbit;
    logic [BYTE_W-1:0] data;
  } fifo_word_t;

endpackage

// File: rtl/rbm_map_regs.sv
module rbm_map_regs #(
  parameter int NUM_BYTES = 36,
  parameter int REG_BITS  = 6,
  parameter int CFG_W     = 8,
  parameter int NUM_REGS  = (NUM_BYTES + REG_BITS - 1) / REG_BITS,
  parameter int CFG_AW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 blk_load,
  output logic [NUM_BYTES-1:0] map_use
);

  localparam int SHADOW_W = NUM_REGS * REG_BITS;

  logic [SHADOW_W-1:0]  shadow_q, shadow_d;
  logic [NUM_BYTES-1:0] active_q, active_d;

  // One field of the staged mask per register address
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_field
    always_comb begin
      shadow_d[k*REG_BITS +: REG_BITS] = shadow_q[k*REG_BITS +: REG_BITS];
      if (cfg_we && (int'(cfg_addr) == k)) begin
        shadow_d[k*REG_BITS +: REG_BITS] = cfg_wdata[REG_BITS-1:0];
      end
    end
  end

  always_comb begin
    active_d = active_q;
    if (blk_load) begin
      active_d = shadow_q[NUM_BYTES-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  // The block-start byte already uses the staged mask
  assign map_use = blk_load ? shadow_q[NUM_BYTES-1:0] : active_q;

  assert_map_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_load |=> $stable(active_q));

endmodule

// File: rtl/rbm_select.sv
module rbm_select #(
  parameter int NUM_BYTES = 36,
  parameter int IDX_W     = $clog2(NUM_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_start,
  input  logic [NUM_BYTES-1:0] map_use,
  output logic                 sel_hit
);

  localparam int PAD_W = 2 ** IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES);

  logic [IDX_W-1:0] idx_q, idx_d, idx_cur;
  logic [PAD_W-1:0] map_pad;
  logic             in_range;

  assign idx_cur  = in_start ? '0 : idx_q;
  assign in_range = (idx_cur < LAST_IDX);
  assign map_pad  = PAD_W'(map_use);

  always_comb begin
    idx_d = idx_q;
    if (in_valid) begin
      idx_d = (idx_cur == LAST_IDX) ? idx_cur : idx_cur + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else begin
      idx_q <= idx_d;
    end
  end

  assign sel_hit = in_valid && in_range && map_pad[idx_cur];

  assert_idx_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> (idx_cur < LAST_IDX));

  assert_idx_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

endmodule

// File: rtl/rbm_write.sv
module rbm_write
  import rbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t1_mode,
  input  logic              sel_hit,
  input  logic              fifo_full,
  input  logic              in_fbit,
  input  logic [BYTE_W-1:0] in_data,
  output logic              fifo_we,
  output fifo_word_t        fifo_word,
  output logic              overflow
);

  logic       we_d, we_q;
  logic       ovf_d, ovf_q;
  fifo_word_t word_d, word_q;
  logic       fbit_sel;

  assign fbit_sel = t1_mode && in_fbit;
  assign we_d     = sel_hit && !fifo_full;
  assign ovf_d    = ovf_q || (sel_hit && fifo_full);

  always_comb begin
    word_d.fbit = fbit_sel;
    word_d.data = fbit_sel ? {{(BYTE_W-1){1'b0}}, in_data[0]} : in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      we_q  <= we_d;
      ovf_q <= ovf_d;
    end
  end

  // Data register is clock-enabled by the write decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (we_d) begin
      word_q <= word_d;
    end
  end

  assign fifo_we        = we_q;
  assign fifo_word.data = word_q.data;
  assign fifo_word.fbit = word_q.fbit && we_q;
  assign overflow       = ovf_q;

  assert_no_write_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hit && fifo_full) |=> (!fifo_we && overflow));

  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

// File: rtl/rx_byte_mapper.sv
module rx_byte_mapper
  import rbm_pkg::*;
#(
  parameter  int NUM_BYTES = 36,
  parameter  int REG_BITS  = 6,
  localparam int NUM_REGS  = (NUM_BYTES + REG_BITS - 1) / REG_BITS,
  localparam int CFG_AW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t1_mode,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic              in_fbit,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              fifo_full,
  output logic              fifo_we,
  output logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_fbit,
  output logic              overflow
);

  logic                 rst_s0, rst_sync_n;
  logic                 blk_load;
  logic [NUM_BYTES-1:0] map_use;
  logic                 sel_hit;
  fifo_word_t           word;

  // Reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  assign blk_load = in_valid && in_start;

  rbm_map_regs #(
    .NUM_BYTES (NUM_BYTES),
    .REG_BITS  (REG_BITS),
    .CFG_W     (BYTE_W),
    .NUM_REGS  (NUM_REGS),
    .CFG_AW    (CFG_AW)
  ) u_map (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .blk_load  (blk_load),
    .map_use   (map_use)
  );

  rbm_select #(
    .NUM_BYTES (NUM_BYTES)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .map_use  (map_use),
    .sel_hit  (sel_hit)
  );

  rbm_write u_wr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .t1_mode   (t1_mode),
    .sel_hit   (sel_hit),
    .fifo_full (fifo_full),
    .in_fbit   (in_fbit),
    .in_data   (in_data),
    .fifo_we   (fifo_we),
    .fifo_word (word),
    .overflow  (overflow)
  );

  assign fifo_data = word.data;
  assign fifo_fbit = word.fbit;

  assert_write_follows_byte_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fifo_we |-> $past(in_valid && !fifo_full));

  assert_fbit_needs_mode_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fifo_fbit |-> (fifo_we && $past(t1_mode && in_fbit)));

  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_sync_n |-> (!fifo_we && !overflow));

endmodule

// File: tb/tb_rx_byte_mapper.sv
module tb_rx_byte_mapper;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       t1_mode;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       in_valid, in_start, in_fbit, fifo_full;
  logic [7:0] in_data;
  logic       fifo_we, fifo_fbit, overflow;
  logic [7:0] fifo_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rx_byte_mapper dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .t1_mode   (t1_mode),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .in_valid  (in_valid),
    .in_start  (in_start),
    .in_fbit   (in_fbit),
    .in_data   (in_data),
    .fifo_full (fifo_full),
    .fifo_we   (fifo_we),
    .fifo_data (fifo_data),
    .fifo_fbit (fifo_fbit),
    .overflow  (overflow)
  );

  // {start, fbit, full, data[7:0], exp_we, exp_data[7:0]}
  // Mask in force: bits 0, 2, 3, 12 and 35 set; t1_mode = 0.
  localparam logic [19:0] VEC [0:8] = '{
    {1'b1, 1'b0, 1'b0, 8'hA0, 1'b1, 8'hA0},  // pos 0 selected (R1)
    {1'b0, 1'b0, 1'b0, 8'hA1, 1'b0, 8'h00},  // pos 1 dropped (R1)
    {1'b0, 1'b0, 1'b0, 8'hA2, 1'b1, 8'hA2},  // pos 2 selected
    {1'b0, 1'b0, 1'b1, 8'hA3, 1'b0, 8'h00},  // pos 3 selected but full (R6)
    {1'b0, 1'b0, 1'b0, 8'hA4, 1'b0, 8'h00},  // pos 4 dropped
    {1'b1, 1'b0, 1'b0, 8'hB0, 1'b1, 8'hB0},  // restart at pos 0 (R4)
    {1'b0, 1'b1, 1'b0, 8'hB1, 1'b0, 8'h00},  // flag ignored, pos 1 dropped (R7)
    {1'b0, 1'b1, 1'b0, 8'hB2, 1'b1, 8'hB2},  // flag ignored, data intact (R7)
    {1'b1, 1'b0, 1'b0, 8'hC0, 1'b1, 8'hC0}   // restart again
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Present one byte, then sample its result in the cycle it is due
  task automatic step(input logic s, input logic f, input logic fl, input logic [7:0] d);
    in_valid  = 1'b1;
    in_start  = s;
    in_fbit   = f;
    fifo_full = fl;
    in_data   = d;
    @(posedge clk);
    @(negedge clk);
    in_valid  = 1'b0;
    in_start  = 1'b0;
    in_fbit   = 1'b0;
    fifo_full = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t1_mode = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_start = 1'b0; in_fbit = 1'b0; fifo_full = 1'b0; in_data = '0;
    @(negedge clk);
    do_reset();

    // R8: quiet outputs and an empty mask after reset
    chk("R8 fifo_we", fifo_we, 0);
    chk("R8 overflow", overflow, 0);
    chk("R8 fifo_fbit", fifo_fbit, 0);
    step(1'b1, 1'b0, 1'b0, 8'h55);
    chk("R8 empty mask", fifo_we, 0);

    // R2: junk in bits 7:6 must not matter
    wr(3'd0, 8'hCD);
    wr(3'd2, 8'h41);
    wr(3'd5, 8'hE0);

    for (int i = 0; i < 9; i++) begin
      step(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
      chk($sformatf("R1 vec%0d we", i), fifo_we, VEC[i][8]);
      chk($sformatf("R7 vec%0d fbit", i), fifo_fbit, 0);
      if (VEC[i][8]) chk($sformatf("R5 vec%0d data", i), fifo_data, VEC[i][7:0]);
    end
    chk("R6 overflow set", overflow, 1);
    repeat (3) @(negedge clk);
    chk("R6 overflow sticky", overflow, 1);

    // R2/R4: full mask, 40 bytes, only the first 36 are written
    for (int a = 0; a < 6; a++) wr(3'(a), 8'h3F);
    for (int i = 0; i < 40; i++) begin
      step(i == 0, 1'b0, 1'b0, 8'(i + 8'h10));
      chk($sformatf("R4 pos%0d we", i), fifo_we, (i < 36));
      if (i == 35) chk("R2 pos35 data", fifo_data, 8'h33);
    end
    chk("R5 single pulse", fifo_we, 1'b0);
    @(negedge clk);
    chk("R5 idle no write", fifo_we, 0);

    // R3: a write inside a block is deferred to the next start
    step(1'b1, 1'b0, 1'b0, 8'h60);
    chk("R3 old mask pos0", fifo_we, 1);
    wr(3'd0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h61);
    chk("R3 old mask pos1 we", fifo_we, 1);
    chk("R3 old mask pos1 data", fifo_data, 8'h61);
    step(1'b1, 1'b0, 1'b0, 8'h70);
    chk("R3 new mask pos0", fifo_we, 0);
    step(1'b0, 1'b0, 1'b0, 8'h71);
    chk("R3 new mask pos1", fifo_we, 0);

    // R2: out-of-range addresses change nothing
    wr(3'd6, 8'h3F);
    wr(3'd7, 8'h3F);
    step(1'b1, 1'b0, 1'b0, 8'h80);
    chk("R2 addr 6/7 ignored", fifo_we, 0);

    // R7: two T1 streams, framing byte at position 12
    t1_mode = 1'b1;
    wr(3'd0, 8'h3F); wr(3'd1, 8'h3F); wr(3'd2, 8'h01);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    for (int i = 0; i < 12; i++) begin
      step(i == 0, 1'b0, 1'b0, 8'(8'h20 + i));
      if (i == 0 || i == 11) chk("R7 payload written", fifo_we, 1);
    end
    step(1'b0, 1'b1, 1'b0, 8'hA7);
    chk("R7 fbit we", fifo_we, 1);
    chk("R7 fbit data", fifo_data, 8'h01);
    chk("R7 fbit flag", fifo_fbit, 1);
    step(1'b0, 1'b0, 1'b0, 8'h99);
    chk("R1 pos13 dropped", fifo_we, 0);

    wr(3'd2, 8'h00);
    for (int i = 0; i < 12; i++) step(i == 0, 1'b0, 1'b0, 8'(i));
    step(1'b0, 1'b1, 1'b0, 8'hA7);
    chk("R7 fbit masked off", fifo_we, 0);
    chk("R7 fbit flag low", fifo_fbit, 0);
    t1_mode = 1'b0;

    // R6/R8: overflow clears only by reset
    chk("R6 still set", overflow, 1);
    do_reset();
    chk("R8 overflow cleared", overflow, 0);
    step(1'b1, 1'b0, 1'b0, 8'h11);
    chk("R8 mask cleared", fifo_we, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule